// File: doc/BRIEF.md
# Hardwired 8-bit Multi-cycle Processor Core

This block is a small 8-bit processor with four general registers and no accumulator. It fetches byte-wide instructions from an external program memory and executes a set of ten. The set covers reading an 8-bit switch value, loading an immediate, storing and loading through a register-held RAM address, writing a register to an LED output register, unsigned compare, increment, decrement, an absolute jump and a jump taken when the last compare found its first operand below its second.

Control is a hardwired multi-cycle sequencer. Every machine step spans four clock phases, and each instruction uses two steps: a fetch step and an execute step. The instruction and address registers load on the third phase of a step. The program counter, the general registers, the flags and the LED register load on the fourth phase. The data RAM is external and combinationally read, and it has 32 bytes indexed by the low five address bits. A typical use is a short program that reads ten values from the switches, sorts them in RAM and then writes them out one by one.

Top module: `cpu8_core`

## Requirements
- R1: While reset is low, the program counter (`imem_addr`), all four registers, both flags and `led_out` are zero, and `led_we` and `dmem_we` are low.
- R2: An instruction byte holds the opcode in bits 7:4, the source register field in bits 3:2 and the destination field in bits 1:0, with register code n selecting Rn. Opcode 1000 copies `sw_in` into Rd. Opcode 1100 copies Rs into `led_out` and raises `led_we` for exactly one clock. `led_out` holds its value until the next such instruction.
- R3: Opcode 1001 is two bytes long and loads its second byte into Rd. Opcode 1010 writes Rs into RAM at address Rd[4:0].
- R4: Opcode 1011 loads RAM[Rs[4:0]] into Rd.
- R5: Opcode 1111 adds 1 to Rd and opcode 1110 subtracts 1 from Rd, both modulo 256 (FF+1=00, 00-1=FF).
- R6: Opcode 1101 computes Rs−Rd unsigned and writes no register. It latches a borrow flag (Rs<Rd) and a zero flag (Rs=Rd). Opcode 0111 is two bytes long and loads the PC with its second byte when the borrow is set; otherwise execution continues after that byte. No other instruction changes the flags.
- R7: Opcode 0110 is two bytes long and loads the PC with its second byte. The PC wraps from FF to 00.
- R8: Every instruction, whether one or two bytes long, takes exactly 8 clocks. The PC changes only on the last phase of a step, and the RAM write strobe lasts one clock.
- R9: A bubble-sort program built from these instructions reads ten unsigned switch values and outputs them in ascending order. This holds with duplicate values and with zero among the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Program memory address (the PC) |
| imem_data | input | 8 | Program memory byte at imem_addr |
| dmem_addr | output | 5 | Data RAM address |
| dmem_wdata | output | 8 | Data RAM write data |
| dmem_we | output | 1 | Data RAM write strobe, one clock |
| dmem_rdata | input | 8 | Data RAM read data at dmem_addr |
| sw_in | input | 8 | Switch input value |
| led_out | output | 8 | LED output register |
| led_we | output | 1 | One-clock pulse after led_out loads |

## Verification
A wrong register or flag stays hidden until an output, store or branch exposes it. The tests therefore end each directed program with an output instruction or a branch to one of two marker outputs, so a fault appears on `led_out` within one or two instructions. A sequencing fault shows up sooner, in the spacing of `led_we` pulses or in the fetch addresses. The sort program is the deepest test. One wrong swap or compare corrupts the final ascending sequence, and that sequence is checked value by value.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned OP_W     = 4;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned NUM_REGS = 1 << SEL_W;
    localparam int unsigned RAM_AW   = 5;
    localparam int unsigned PHASES   = 4;
    localparam int unsigned PHASE_W  = $clog2(PHASES);

    localparam logic [PHASE_W-1:0] PH_LOAD_IR = PHASE_W'(PHASES - 2);
    localparam logic [PHASE_W-1:0] PH_COMMIT  = PHASE_W'(PHASES - 1);

    localparam logic [OP_W-1:0] OP_JMP  = 4'b0110;
    localparam logic [OP_W-1:0] OP_JB   = 4'b0111;
    localparam logic [OP_W-1:0] OP_IN   = 4'b1000;
    localparam logic [OP_W-1:0] OP_MOVI = 4'b1001;
    localparam logic [OP_W-1:0] OP_ST   = 4'b1010;
    localparam logic [OP_W-1:0] OP_LD   = 4'b1011;
    localparam logic [OP_W-1:0] OP_OUT  = 4'b1100;
    localparam logic [OP_W-1:0] OP_CMP  = 4'b1101;
    localparam logic [OP_W-1:0] OP_DEC  = 4'b1110;
    localparam logic [OP_W-1:0] OP_INC  = 4'b1111;

    typedef enum logic {
        STEP_FETCH = 1'b0,
        STEP_EXEC  = 1'b1
    } step_e;

    typedef struct packed {
        step_e                              step;
        logic [PHASE_W-1:0]                 phase;
        logic [DATA_W-1:0]                  pc;
        logic [DATA_W-1:0]                  ir;
        logic [RAM_AW-1:0]                  ar;
        logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
        logic                               borrow;
        logic                               zero;
        logic [DATA_W-1:0]                  led;
        logic                               led_we;
    } core_state_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [DATA_W-1:0] ir,
    output logic [OP_W-1:0]   op,
    output logic [SEL_W-1:0]  rs,
    output logic [SEL_W-1:0]  rd
);
    assign op = ir[DATA_W-1 -: OP_W];
    assign rs = ir[2*SEL_W-1 -: SEL_W];
    assign rd = ir[SEL_W-1:0];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    output logic [DATA_W-1:0] result,
    output logic              borrow,
    output logic              zero
);
    logic [DATA_W:0] diff;

    always_comb begin
        diff   = {1'b0, src_val} - {1'b0, dst_val};
        borrow = diff[DATA_W];
        zero   = (diff[DATA_W-1:0] == '0);
        case (op)
            OP_INC:  result = dst_val + 1'b1;
            OP_DEC:  result = dst_val - 1'b1;
            default: result = diff[DATA_W-1:0];
        endcase
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [DATA_W-1:0]    imem_addr,
    input  logic [DATA_W-1:0]    imem_data,
    output logic [RAM_AW-1:0]    dmem_addr,
    output logic [DATA_W-1:0]    dmem_wdata,
    output logic                 dmem_we,
    input  logic [DATA_W-1:0]    dmem_rdata,
    input  logic [DATA_W-1:0]    sw_in,
    output logic [DATA_W-1:0]    led_out,
    output logic                 led_we
);
    core_state_t s_q, s_d;

    logic [OP_W-1:0]   op;
    logic [SEL_W-1:0]  rs, rd;
    logic [DATA_W-1:0] alu_res;
    logic              alu_borrow, alu_zero;
    logic              exec_commit;
    logic              cmp_commit;
    logic [PHASE_W-1:0] phase_q;
    logic [1:0]         flags_q;

    cpu8_decode dec_i (
        .ir (s_q.ir),
        .op (op),
        .rs (rs),
        .rd (rd)
    );

    cpu8_alu alu_i (
        .op      (op),
        .src_val (s_q.regs[rs]),
        .dst_val (s_q.regs[rd]),
        .result  (alu_res),
        .borrow  (alu_borrow),
        .zero    (alu_zero)
    );

    assign exec_commit = (s_q.step == STEP_EXEC) && (s_q.phase == PH_COMMIT);
    assign cmp_commit  = exec_commit && (op == OP_CMP);

    always_comb begin
        s_d        = s_q;
        s_d.phase  = s_q.phase + 1'b1;
        s_d.led_we = 1'b0;

        if (s_q.phase == PH_LOAD_IR) begin
            if (s_q.step == STEP_FETCH) begin
                s_d.ir = imem_data;
            end else if (op == OP_LD) begin
                s_d.ar = s_q.regs[rs][RAM_AW-1:0];
            end else begin
                s_d.ar = s_q.regs[rd][RAM_AW-1:0];
            end
        end

        if (s_q.phase == PH_COMMIT) begin
            if (s_q.step == STEP_FETCH) begin
                s_d.pc   = s_q.pc + 1'b1;
                s_d.step = STEP_EXEC;
            end else begin
                s_d.step = STEP_FETCH;
                case (op)
                    OP_IN:   s_d.regs[rd] = sw_in;
                    OP_MOVI: begin
                        s_d.regs[rd] = imem_data;
                        s_d.pc       = s_q.pc + 1'b1;
                    end
                    OP_LD:   s_d.regs[rd] = dmem_rdata;
                    OP_OUT:  begin
                        s_d.led    = s_q.regs[rs];
                        s_d.led_we = 1'b1;
                    end
                    OP_CMP:  begin
                        s_d.borrow = alu_borrow;
                        s_d.zero   = alu_zero;
                    end
                    OP_INC, OP_DEC: s_d.regs[rd] = alu_res;
                    OP_JMP:  s_d.pc = imem_data;
                    OP_JB:   s_d.pc = s_q.borrow ? imem_data : s_q.pc + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr  = s_q.pc;
    assign dmem_addr  = s_q.ar;
    assign dmem_wdata = s_q.regs[rs];
    assign dmem_we    = exec_commit && (op == OP_ST);
    assign led_out    = s_q.led;
    assign led_we     = s_q.led_we;
    assign phase_q    = s_q.phase;
    assign flags_q    = {s_q.borrow, s_q.zero};
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
    import cpu8_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [PHASE_W-1:0]   phase,
    input logic [DATA_W-1:0]    imem_addr,
    input logic [DATA_W-1:0]    led_out,
    input logic                 led_we,
    input logic                 dmem_we,
    input logic                 cmp_commit,
    input logic [1:0]           flags
);
    // R1: reset clears PC and LED state
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0 && led_out == '0 && !led_we && !dmem_we));

    // R2: LED register holds between output instructions
    p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !led_we |-> $stable(led_out));

    // R2: LED pulse lasts one clock
    p_led_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        led_we |=> !led_we);

    // R8: PC moves only across the last phase of a step
    p_pc_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(imem_addr));

    // R8: RAM write strobe lasts one clock, then a new step begins
    p_store_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (!dmem_we && phase == '0));

    // R6: only compare updates the flags
    p_flags_cmp_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_commit |=> $stable(flags));
endmodule

bind cpu8_core cpu8_core_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_q),
    .imem_addr  (imem_addr),
    .led_out    (led_out),
    .led_we     (led_we),
    .dmem_we    (dmem_we),
    .cmp_commit (cmp_commit),
    .flags      (flags_q)
);

// File: tb/cpu8_core_tb_top.sv
`timescale 1ns/1ps
module cpu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] imem_addr, imem_data, dmem_wdata, dmem_rdata, sw_in, led_out;
    logic [4:0] dmem_addr;
    logic       dmem_we, led_we;

    always #2.5 clk = ~clk;

    logic [7:0] prog [256];
    logic [7:0] ram  [32];
    logic [7:0] sw_vals [10];
    int sw_idx = 0;
    logic [7:0] outs [64];
    int out_t [64];
    int out_cnt = 0;
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int wp = 0;

    assign imem_data  = prog[imem_addr];
    assign dmem_rdata = ram[dmem_addr];
    assign sw_in      = sw_vals[(sw_idx > 9) ? 9 : sw_idx];

    cpu8_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .sw_in(sw_in),
        .led_out(led_out), .led_we(led_we)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && dmem_we) ram[dmem_addr] = dmem_wdata;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (led_we && out_cnt < 64) begin
                outs[out_cnt]  = led_out;
                out_t[out_cnt] = cyc;
                out_cnt        = out_cnt + 1;
            end
            if (dmem_we) sw_idx = sw_idx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        for (int i = 0; i < 32; i++) ram[i] = 8'h00;
        for (int i = 0; i < 10; i++) sw_vals[i] = 8'h00;
        wp = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        prog[wp[7:0]] = b;
        wp = wp + 1;
    endtask

    task automatic run(input int cycles, input bit check_reset);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        sw_idx  = 0;
        out_cnt = 0;
        if (check_reset) begin
            chk(imem_addr == 8'h00, "R1 pc", imem_addr, 0);
            chk(led_out == 8'h00, "R1 led", led_out, 0);
            chk(!led_we && !dmem_we, "R1 strobes", {led_we, dmem_we}, 0);
        end
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic sort_case(input logic [7:0] v [10]);
        logic [7:0] e [10];
        logic [7:0] t;
        clear_all();
        for (int i = 0; i < 10; i++) begin sw_vals[i] = v[i]; e[i] = v[i]; end
        for (int i = 1; i < 10; i++)
            for (int j = i; j > 0 && e[j-1] > e[j]; j--) begin
                t = e[j]; e[j] = e[j-1]; e[j-1] = t;
            end
        emit(8'h90); emit(8'h0A); emit(8'h91); emit(8'h00);
        emit(8'h82); emit(8'hA9); emit(8'hF1); emit(8'hD4); emit(8'h70); emit(8'h04);
        emit(8'h90); emit(8'h09); emit(8'h91); emit(8'h00);
        emit(8'hB6); emit(8'hF1); emit(8'hD1); emit(8'h70); emit(8'd31);
        emit(8'hB7); emit(8'hDE); emit(8'h70); emit(8'd25); emit(8'h60); emit(8'd14);
        emit(8'hA9); emit(8'hE1); emit(8'hAD); emit(8'hF1); emit(8'h60); emit(8'd14);
        emit(8'hE0); emit(8'h91); emit(8'h00); emit(8'hD4); emit(8'h70); emit(8'd14);
        emit(8'h90); emit(8'h0A); emit(8'h91); emit(8'h00);
        emit(8'hB6); emit(8'hF1); emit(8'hC8); emit(8'hD4); emit(8'h70); emit(8'd41);
        emit(8'h60); emit(8'd47);
        run(15000, 1'b0);
        chk(out_cnt == 10, "R9 output count", out_cnt, 10);
        for (int i = 0; i < 10; i++)
            chk(outs[i] == e[i], "R9 sorted value", outs[i], e[i]);
    endtask

    task automatic branch_case(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] exp;
        clear_all();
        emit(8'h90); emit(a); emit(8'h91); emit(b);
        emit(8'hD1); emit(8'hF0); emit(8'hE1);
        emit(8'h70); emit(8'd13);
        emit(8'hC8); emit(8'h60); emit(8'd10);
        emit(8'h00);
        emit(8'h92); emit(8'h22); emit(8'hC8); emit(8'h60); emit(8'd16);
        run(200, 1'b0);
        exp = (a < b) ? 8'h22 : 8'h00;
        chk(out_cnt >= 1 && outs[0] == exp, "R6 compare/branch", outs[0], exp);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v [10];
        void'($urandom(32'd1234));

        // R1 + R2: reset state, input, output, register reset
        clear_all();
        sw_vals[0] = 8'h99;
        emit(8'h80); emit(8'hC0); emit(8'hCC); emit(8'h60); emit(8'h03);
        run(100, 1'b1);
        chk(out_cnt == 2, "R2 output count", out_cnt, 2);
        chk(outs[0] == 8'h99, "R2 switch to led", outs[0], 8'h99);
        chk(outs[1] == 8'h00, "R1 register reset", outs[1], 0);
        chk(led_out == 8'h00, "R2 led holds", led_out, 0);

        // R3: immediate + store with low five address bits
        clear_all();
        emit(8'h92); emit(8'h5C); emit(8'h91); emit(8'h33); emit(8'hA9);
        emit(8'h60); emit(8'h05);
        run(100, 1'b0);
        chk(ram[19] == 8'h5C, "R3 store", ram[19], 8'h5C);

        // R4: load indirect
        clear_all();
        emit(8'h90); emit(8'h27); emit(8'hB1); emit(8'hC4); emit(8'h60); emit(8'h04);
        rst_n = 1'b0; ram[7] = 8'h77;
        run(100, 1'b0);
        chk(out_cnt >= 1 && outs[0] == 8'h77, "R4 load", outs[0], 8'h77);

        // R5: increment and decrement wrap
        clear_all();
        emit(8'h90); emit(8'hFF); emit(8'hF0); emit(8'hC0); emit(8'hE1); emit(8'hC4);
        emit(8'h60); emit(8'h06);
        run(150, 1'b0);
        chk(outs[0] == 8'h00, "R5 inc wrap", outs[0], 0);
        chk(outs[1] == 8'hFF, "R5 dec wrap", outs[1], 8'hFF);

        // R6: compare / jump-if-below, flags kept across inc/dec
        branch_case(8'd3, 8'd9);
        branch_case(8'd9, 8'd3);
        branch_case(8'h50, 8'h50);
        branch_case(8'h00, 8'hFF);
        for (int k = 0; k < 6; k++) branch_case(8'($urandom), 8'($urandom));

        // R7 + R8: jump, PC wrap, instruction length
        clear_all();
        emit(8'hC0); emit(8'hF0); emit(8'h60); emit(8'hFF);
        prog[255] = 8'hF1;
        run(120, 1'b0);
        chk(outs[0] == 8'h00 && outs[1] == 8'h01 && outs[2] == 8'h02, "R7 pc wrap",
            {outs[0], outs[1], outs[2]}, 24'h000102);
        chk(out_t[1] - out_t[0] == 32, "R8 8 clocks per instruction", out_t[1] - out_t[0], 32);
        chk(out_t[2] - out_t[1] == 32, "R8 8 clocks per instruction", out_t[2] - out_t[1], 32);

        // R9: sort program
        v = '{8'd34, 8'd15, 8'd25, 8'd92, 8'd17, 8'd6, 8'd83, 8'd68, 8'd72, 8'd87};
        sort_case(v);
        v = '{8'd34, 8'd15, 8'd25, 8'd92, 8'd83, 8'd6, 8'd83, 8'd68, 8'd72, 8'd87};
        sort_case(v);
        v = '{8'd34, 8'd0, 8'd25, 8'd92, 8'd83, 8'd6, 8'd83, 8'd68, 8'd72, 8'd87};
        sort_case(v);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 10; i++) v[i] = 8'($urandom);
            sort_case(v);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule